// File: doc/BRIEF.md
# Escalating Watchdog with Standby Failover

This block supervises one primary processing unit that must prove it is alive by pulsing a kick input at least once per timeout period. If the kicks stop, or an external checker raises the error input, the watchdog drives a reset pulse of fixed length into the primary unit and adds one to a reset tally.

The tally is judged at the end of each fixed evaluation window, counted from the global reset. A tally at or below the limit is cleared and a fresh window opens. A tally above the limit marks the primary as permanently broken. The block then raises a sticky fault flag and enables a standby unit. From that point the watchdog leaves the failed primary alone and freezes its tally.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `esc_watchdog`

## Requirements
- R1: The timeout counter reloads on every kick and while a reset pulse is being issued. When TIMEOUT_CYC consecutive clock edges pass with no kick and no reset pulse, the watchdog starts a reset pulse.
- R2: A high error input on a clock edge starts a reset pulse, visible on the reset output after that edge.
- R3: The reset output stays high for exactly HOLD_CYC cycles. Kicks and errors that arrive while it is high are ignored: they start no new pulse and do not change the tally.
- R4: Each reset pulse that starts adds one to the tally on the reset-count output. A timeout and an error on the same edge count once.
- R5: The tally saturates at 2**CNT_W-1 and never wraps.
- R6: Every WINDOW_CYC-th clock edge after reset is a window end. At a window end where the tally is greater than LIMIT_K, the fault flag and standby enable go high after that edge.
- R7: At a window end where the tally is not above LIMIT_K, the tally returns to zero, and a new window begins.
- R8: Fault flag and standby enable remain high until the global reset. Once they are high, no new reset pulse starts and the tally holds its value.
- R9: During and right after the global reset, the reset output, fault flag and standby enable are low and the tally is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| kick_i | input | 1 | Alive pulse from the primary unit |
| err_i | input | 1 | Error reported by an external checker |
| unit_rst_o | output | 1 | Reset to the primary unit, active high |
| fault_o | output | 1 | Sticky permanent-fault flag |
| standby_en_o | output | 1 | Sticky enable for the standby unit |
| reset_count_o | output | CNT_W | Resets counted in the current window |

## Verification
The embedded assertions check properties that must hold on every cycle:
- the timeout counter stays within its range;
- every rising edge of the reset output has a trigger behind it;
- the tally either steps by one or saturates;
- the fault flag stays high once set;
- once failover has settled, the reset output stays low and the tally stays frozen.

Some behaviour depends on exact cycle positions, and only the bench scenarios can show it:
- the edge on which a timeout fires;
- the pulse length;
- kicks and errors ignored during a pulse;
- a timeout and an error on the same edge counted once;
- the window-end decision, which either clears the tally or escalates to failover.

// File: rtl/esc_wd_pkg.sv
package esc_wd_pkg;
  // Cause of a reset request, bit 1 = error input, bit 0 = timeout expiry
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_TIMEOUT = 2'b01,
    CAUSE_ERROR   = 2'b10,
    CAUSE_BOTH    = 2'b11
  } wd_cause_e;
endpackage

// File: rtl/esc_wd_timer.sv
module esc_wd_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic hold_i,
  input  logic restart_i,
  input  logic freeze_i,
  output logic expire_o
);
  localparam int TMO_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TMO_W-1:0] LAST = TMO_W'(TIMEOUT_CYC - 1);

  logic [TMO_W-1:0] tmo_q;

  assign expire_o = !freeze_i && !hold_i && !kick_i && (tmo_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= '0;
    end else if (freeze_i) begin
      tmo_q <= tmo_q;
    end else if (hold_i || kick_i || restart_i) begin
      tmo_q <= '0;
    end else begin
      tmo_q <= tmo_q + 1'b1;
    end
  end

  // R1: counter never runs past its terminal value
  assert_tmo_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q <= LAST);

  // R1: a kick always brings the counter back to zero
  assert_kick_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && !freeze_i) |=> (tmo_q == '0));
endmodule

// File: rtl/esc_wd_pulse.sv
module esc_wd_pulse #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic kill_i,
  output logic active_o
);
  localparam int HLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [HLD_W-1:0] LOAD = HLD_W'(HOLD_CYC);

  logic [HLD_W-1:0] hold_q;

  assign active_o = (hold_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (kill_i) begin
      hold_q <= '0;
    end else if (start_i) begin
      hold_q <= LOAD;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  // R3: a start request always produces a pulse unless killed
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !kill_i) |=> active_o);

  // R3: a pulse only rises after a start request
  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(start_i));
endmodule

// File: rtl/esc_wd_judge.sv
module esc_wd_judge #(
  parameter int WINDOW_CYC = 1024,
  parameter int LIMIT_K    = 3,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fault_o
);
  localparam int WIN_W = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(LIMIT_K);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;
  logic             win_end;
  logic             escalate;

  assign win_end  = (win_q == WIN_LAST);
  assign escalate = win_end && (cnt_q > LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (!fault_q) begin
      win_q <= win_end ? '0 : win_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!fault_q) begin
      if (escalate) begin
        fault_q <= 1'b1;
      end else if (win_end) begin
        cnt_q <= inc_i ? CNT_W'(1) : '0;
      end else if (inc_i && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
  assign fault_o = fault_q;

  // R4/R5: inside a window the tally only steps by one or stays put
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !fault_q && inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R8: fault is sticky
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

  // R6: fault can only rise at a window end with an excess tally
  assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(win_end && cnt_q > LIMIT));
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog #(
  parameter int TIMEOUT_CYC = 16,
  parameter int HOLD_CYC    = 4,
  parameter int WINDOW_CYC  = 1024,
  parameter int LIMIT_K     = 3,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick_i,
  input  logic             err_i,
  output logic             unit_rst_o,
  output logic             fault_o,
  output logic             standby_en_o,
  output logic [CNT_W-1:0] reset_count_o
);
  import esc_wd_pkg::*;

  logic      expire;
  logic      hold_active;
  logic      fault;
  logic      trigger;
  wd_cause_e cause;

  assign cause   = wd_cause_e'({err_i, expire});
  assign trigger = (cause != CAUSE_NONE) && !hold_active && !fault;

  esc_wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_i    (kick_i),
    .hold_i    (hold_active),
    .restart_i (trigger),
    .freeze_i  (fault),
    .expire_o  (expire)
  );

  esc_wd_pulse #(.HOLD_CYC(HOLD_CYC)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (trigger),
    .kill_i   (fault),
    .active_o (hold_active)
  );

  esc_wd_judge #(
    .WINDOW_CYC (WINDOW_CYC),
    .LIMIT_K    (LIMIT_K),
    .CNT_W      (CNT_W)
  ) u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (trigger),
    .count_o (reset_count_o),
    .fault_o (fault)
  );

  assign unit_rst_o   = hold_active;
  assign fault_o      = fault;
  assign standby_en_o = fault;

  // R2: every rising reset edge comes from a timeout or an error
  assert_rst_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_rst_o) |-> $past(trigger));

  // R8: once failover has settled the primary sees no reset
  assert_no_rst_after_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && $past(fault_o)) |-> !unit_rst_o);

  // R8: tally frozen after failover
  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> $stable(reset_count_o));
endmodule

// File: tb/test_esc_watchdog.sv
module test_esc_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 6;
  localparam int HOLD = 2;
  localparam int WIN  = 40;
  localparam int LIM  = 2;
  localparam int CW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kick = 1'b0;
  logic          err = 1'b0;
  logic          unit_rst;
  logic          fault;
  logic          standby;
  logic [CW-1:0] rcount;

  int total = 0;
  int bad = 0;
  int edge_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_watchdog #(
    .TIMEOUT_CYC(TMO), .HOLD_CYC(HOLD), .WINDOW_CYC(WIN),
    .LIMIT_K(LIM), .CNT_W(CW)
  ) i_esc_watchdog (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .err_i(err),
    .unit_rst_o(unit_rst), .fault_o(fault), .standby_en_o(standby),
    .reset_count_o(rcount)
  );

  // Row: {kick, err, exp_rst, exp_cnt[2:0]}; one row per clock edge after reset
  localparam logic [5:0] TBL [0:20] = '{
    {1'b1,1'b0,1'b0,3'd0},  // 1  R1 kick
    {1'b1,1'b0,1'b0,3'd0},  // 2  R1 kick
    {1'b0,1'b1,1'b1,3'd1},  // 3  R2 error -> pulse, R4 count
    {1'b1,1'b0,1'b1,3'd1},  // 4  R3 kick ignored in pulse
    {1'b0,1'b1,1'b0,3'd1},  // 5  R3 error ignored, pulse ends
    {1'b0,1'b0,1'b0,3'd1},  // 6  R1 idle
    {1'b0,1'b0,1'b0,3'd1},  // 7
    {1'b0,1'b0,1'b0,3'd1},  // 8
    {1'b0,1'b0,1'b0,3'd1},  // 9
    {1'b0,1'b0,1'b0,3'd1},  // 10
    {1'b0,1'b0,1'b1,3'd2},  // 11 R1 timeout fires
    {1'b0,1'b1,1'b1,3'd2},  // 12 R3 error ignored
    {1'b0,1'b0,1'b0,3'd2},  // 13 R3 pulse ends after HOLD
    {1'b0,1'b0,1'b0,3'd2},  // 14
    {1'b0,1'b0,1'b0,3'd2},  // 15
    {1'b0,1'b0,1'b0,3'd2},  // 16
    {1'b0,1'b0,1'b0,3'd2},  // 17
    {1'b0,1'b0,1'b0,3'd2},  // 18
    {1'b0,1'b1,1'b1,3'd3},  // 19 R4 timeout + error counted once
    {1'b0,1'b0,1'b1,3'd3},  // 20
    {1'b0,1'b0,1'b0,3'd3}   // 21
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0d expected=%0d", req, edge_n, act, exp);
    end
  endtask

  // Drive inputs at negedge, let one posedge pass, return at the next negedge
  task automatic step(input logic k, input logic e);
    kick = k;
    err = e;
    @(posedge clk);
    @(negedge clk);
    edge_n++;
    kick = 1'b0;
    err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    kick = 1'b0;
    err = 1'b0;
    repeat (3) @(negedge clk);
    chk(unit_rst == 1'b0 && fault == 1'b0 && standby == 1'b0 && rcount == '0,
        "R9 reset state", int'({unit_rst, fault, standby, rcount}), 0);
    rst_n = 1'b1;
    edge_n = 0;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // Table scenario: timeout, error, pulse length, ignoring, same-edge causes
    do_reset();
    for (int i = 0; i < 21; i++) begin
      step(TBL[i][5], TBL[i][4]);
      chk(unit_rst == TBL[i][3], "R1/R2/R3 reset output", int'(unit_rst), int'(TBL[i][3]));
      chk(rcount == TBL[i][2:0], "R4 reset count", int'(rcount), int'(TBL[i][2:0]));
    end

    // R6: tally 3 > limit 2, escalation at edge 40
    while (edge_n < WIN - 1) step(1'b1, 1'b0);
    chk(fault == 1'b0, "R6 no fault before window end", int'(fault), 0);
    step(1'b1, 1'b0);
    chk(fault == 1'b1, "R6 fault at window end", int'(fault), 1);
    chk(standby == 1'b1, "R6 standby enabled", int'(standby), 1);

    // R8: no further resets, tally frozen, flags sticky
    for (int i = 0; i < 20; i++) begin
      step(1'b0, i[0]);
      chk(unit_rst == 1'b0, "R8 no reset after failover", int'(unit_rst), 0);
    end
    chk(rcount == 3'd3, "R8 tally frozen", int'(rcount), 3);
    chk(fault == 1'b1 && standby == 1'b1, "R8 sticky flags", int'({fault, standby}), 3);

    // R7: tally at limit clears at window end
    do_reset();
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    chk(rcount == 3'd2, "R4 two resets counted", int'(rcount), 2);
    while (edge_n < WIN - 1) step(1'b1, 1'b0);
    chk(rcount == 3'd2, "R7 tally before window end", int'(rcount), 2);
    step(1'b1, 1'b0);
    chk(rcount == 3'd0, "R7 tally cleared", int'(rcount), 0);
    chk(fault == 1'b0 && standby == 1'b0, "R7 no escalation", int'({fault, standby}), 0);

    // R5: ten resets saturate a 3-bit tally at 7
    do_reset();
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      chk(rcount == ((i + 1 > 7) ? 3'd7 : CW'(i + 1)), "R5 saturating count",
          int'(rcount), (i + 1 > 7) ? 7 : i + 1);
    end
    while (edge_n < WIN - 1) step(1'b1, 1'b0);
    chk(rcount == 3'd7, "R5 held at max", int'(rcount), 7);
    step(1'b1, 1'b0);
    chk(fault == 1'b1, "R6 fault from saturated tally", int'(fault), 1);

    // R9: global reset clears the sticky flags
    do_reset();
    finish_up();
  end
endmodule